// File: doc/BRIEF.md
# MultiOp Bundle Expander

This block turns a compacted instruction stream into full-width issue bundles for an eight-slot machine. Operations arrive one 64-bit word at a time on a valid/ready stream, with no filler nops stored between them. Each word carries a cycle-start flag, a slot selector and a count of empty cycles to insert. The block gathers the operations of one issue cycle into a bundle and places each one in the slot its selector names. Slots that no operation fills come out as nops. After a bundle is emitted, the block emits the requested number of all-nop bundles.

A bundle is held open until the next word with the cycle-start flag arrives, or until a one-cycle flush request closes the stream. Either event emits the bundle on the cycle after it. While empty cycles are still due, the block stops taking input. If a second operation in the same bundle targets a slot that is already filled, the block drops that operation and raises a sticky error flag.

Top module: `mop_expander`

## Requirements
- R1: After reset, out_valid is 0, err_dup is 0 and in_ready is 1.
- R2: Word bit 63 is the cycle-start flag. An accepted word with bit 63 clear joins the open bundle. An accepted word with bit 63 set, while a bundle is open, makes the open bundle appear on the outputs in the next cycle, and that word opens a new bundle.
- R3: Word bits 62:60 select the slot (0 to 7). Word bits 56:0 appear in that slot's field of out_payload, at bits 57*slot+56 down to 57*slot, and the slot's bit in out_slot_vld is 1.
- R4: In every emitted bundle, each slot that no operation filled has its out_slot_vld bit at 0 and its payload field all zero.
- R5: Word bits 59:57 of the word that opened a bundle give a count N from 0 to 7. Right after that bundle is emitted, N all-nop bundles follow on consecutive cycles, each with out_valid 1 and out_slot_vld 0. The same bits in the other words of the bundle are ignored.
- R6: in_ready is 0 in every cycle in which one of these all-nop bundles is still to be emitted.
- R7: If an accepted word with bit 63 clear targets a slot already filled in the open bundle, the word is dropped and the slot keeps its first payload. err_dup goes to 1 on the next cycle and stays at 1 until reset.
- R8: While in_flush is 1, in_ready is 0. A flush in a cycle with no empty bundles pending emits the open bundle in the next cycle, followed by its all-nop bundles, and leaves no bundle open. With no bundle open, a flush has no effect. A flush is ignored while empty bundles are pending.
- R9: When no bundle is open, the next accepted word opens one, whatever its bit 63.
- R10: In cycles that emit nothing, out_valid is 0 and out_slot_vld is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts the word this cycle |
| in_word | input | 64 | Operation word: flag, slot, pause count, payload |
| in_flush | input | 1 | End-of-stream request that closes the open bundle |
| out_valid | output | 1 | A bundle is on the outputs this cycle |
| out_slot_vld | output | 8 | Per-slot operation-present bits |
| out_payload | output | 456 | Eight 57-bit slot payloads, slot 0 in the low bits |
| err_dup | output | 1 | Sticky flag for a duplicate slot within a bundle |

## Verification
Every result is registered once, so each is due exactly one clock after the edge that causes it. A closing word or a flush at edge k puts the bundle out after edge k. The empty bundles follow after edges k+1 through k+N, and in_ready comes back only after edge k+N. err_dup rises one edge after the duplicate word is accepted. The bench's reference model steps at each rising edge and produces the outputs it predicts for that edge. The outputs are compared with those predictions at the falling edge, and inputs change only just after a rising edge, so every comparison lands in the cycle where the result is due.

// File: rtl/mop_expander.sv
module mop_expander #(
  parameter int SLOTS  = 8,
  parameter int OPW    = 64,
  parameter int PAUSEW = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    in_valid,
  output logic                                    in_ready,
  input  logic [OPW-1:0]                          in_word,
  input  logic                                    in_flush,
  output logic                                    out_valid,
  output logic [SLOTS-1:0]                        out_slot_vld,
  output logic [SLOTS*(OPW-1-$clog2(SLOTS)-PAUSEW)-1:0] out_payload,
  output logic                                    err_dup
);
  localparam int TW   = $clog2(SLOTS);
  localparam int PAYW = OPW - 1 - TW - PAUSEW;

  logic                          open_q, err_q, ov_q;
  logic [SLOTS-1:0]              vld_q, ovld_q, new_vld;
  logic [SLOTS-1:0][PAYW-1:0]    pay_q, opay_q, new_pay;
  logic [PAUSEW-1:0]             pause_q, cnt_q;

  wire            hdr = in_word[OPW-1];
  wire [TW-1:0]   typ = in_word[OPW-2 -: TW];
  wire [PAUSEW-1:0] pz = in_word[OPW-2-TW -: PAUSEW];
  wire [PAYW-1:0] pay = in_word[PAYW-1:0];

  assign in_ready     = (cnt_q == '0) && !in_flush;
  assign out_valid    = ov_q;
  assign out_slot_vld = ovld_q;
  assign out_payload  = opay_q;
  assign err_dup      = err_q;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      new_vld[i] = (typ == TW'(i));
      new_pay[i] = (typ == TW'(i)) ? pay : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0; err_q <= 1'b0; ov_q <= 1'b0;
      vld_q <= '0; ovld_q <= '0; pay_q <= '0; opay_q <= '0;
      pause_q <= '0; cnt_q <= '0;
    end else begin
      ov_q   <= 1'b0;
      ovld_q <= '0;
      opay_q <= '0;
      if (cnt_q != '0) begin
        ov_q  <= 1'b1;
        cnt_q <= cnt_q - 1'b1;
      end else if (in_flush) begin
        if (open_q) begin
          ov_q <= 1'b1; ovld_q <= vld_q; opay_q <= pay_q;
          cnt_q <= pause_q; open_q <= 1'b0;
        end
      end else if (in_valid) begin
        if (!open_q || hdr) begin
          if (open_q) begin
            ov_q <= 1'b1; ovld_q <= vld_q; opay_q <= pay_q;
            cnt_q <= pause_q;
          end
          open_q  <= 1'b1;
          vld_q   <= new_vld;
          pay_q   <= new_pay;
          pause_q <= pz;
        end else if (vld_q[typ]) begin
          err_q <= 1'b1;
        end else begin
          vld_q[typ] <= 1'b1;
          pay_q[typ] <= pay;
        end
      end
    end
  end

  p_hdr_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hdr && open_q) |=> (out_valid && out_slot_vld != '0));

  p_pause_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> (out_valid && out_slot_vld == '0));

  p_dup_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hdr && open_q && vld_q[typ]) |=> err_dup);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_dup |=> err_dup);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_slot_vld == '0));

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_nop
      p_nop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_slot_vld[g]) |-> (out_payload[g*PAYW +: PAYW] == '0));
    end
  endgenerate
endmodule

// File: tb/tb_mop_expander.sv
module tb_mop_expander;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_flush = 1'b0;
  logic [63:0] in_word = '0;
  logic in_ready, out_valid, err_dup;
  logic [7:0] out_slot_vld;
  logic [455:0] out_payload;

  mop_expander dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_flush(in_flush), .out_valid(out_valid),
    .out_slot_vld(out_slot_vld), .out_payload(out_payload), .err_dup(err_dup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, armed = 0;

  bit m_open, m_err, e_valid;
  int m_pause, m_cnt;
  bit [7:0] m_vld, e_vld;
  logic [7:0][56:0] m_pay, e_pay;

  function automatic logic [63:0] mk(bit h, int t, int p, logic [56:0] pl);
    return {h, t[2:0], p[2:0], pl};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_err = 0; e_valid = 0; m_pause = 0; m_cnt = 0;
      m_vld = '0; e_vld = '0; m_pay = '0; e_pay = '0;
    end else begin
      bit h; int t;
      h = in_word[63]; t = int'(in_word[62:60]);
      e_valid = 0; e_vld = '0; e_pay = '0;
      if (m_cnt > 0) begin
        e_valid = 1; m_cnt--;
      end else if (in_flush) begin
        if (m_open) begin
          e_valid = 1; e_vld = m_vld; e_pay = m_pay; m_cnt = m_pause; m_open = 0;
        end
      end else if (in_valid) begin
        if (!m_open || h) begin
          if (m_open) begin
            e_valid = 1; e_vld = m_vld; e_pay = m_pay; m_cnt = m_pause;
          end
          m_open = 1; m_vld = '0; m_pay = '0;
          m_vld[t] = 1; m_pay[t] = in_word[56:0];
          m_pause = int'(in_word[59:57]);
        end else if (m_vld[t]) begin
          m_err = 1;
        end else begin
          m_vld[t] = 1; m_pay[t] = in_word[56:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      bit r;
      r = (m_cnt == 0) && !in_flush;
      checks++;
      if (out_valid !== e_valid) begin
        errors++;
        $display("FAIL R2/R5/R10 out_valid: got %b exp %b t=%0t", out_valid, e_valid, $time);
      end
      checks++;
      if (out_slot_vld !== e_vld) begin
        errors++;
        $display("FAIL R3/R4 out_slot_vld: got %h exp %h t=%0t", out_slot_vld, e_vld, $time);
      end
      checks++;
      if (out_payload !== e_pay) begin
        errors++;
        $display("FAIL R3/R4 out_payload: got %h exp %h t=%0t", out_payload, e_pay, $time);
      end
      checks++;
      if (in_ready !== r) begin
        errors++;
        $display("FAIL R6/R8 in_ready: got %b exp %b t=%0t", in_ready, r, $time);
      end
      checks++;
      if (err_dup !== m_err) begin
        errors++;
        $display("FAIL R7 err_dup: got %b exp %b t=%0t", err_dup, m_err, $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send(bit h, int t, int p, logic [56:0] pl);
    bit r;
    in_valid = 1; in_word = mk(h, t, p, pl);
    do begin
      r = in_ready;
      @(posedge clk); #1;
    end while (!r);
    in_valid = 0; in_word = '0;
  endtask

  task automatic flush();
    while (!in_ready) begin @(posedge clk); #1; end
    in_flush = 1;
    @(posedge clk); #1;
    in_flush = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    #1;
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || err_dup !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got v=%b e=%b r=%b exp 0 0 1", out_valid, err_dup, in_ready);
    end
    @(negedge clk); armed = 1;
    @(posedge clk); #1;
    // R2 R3 R4: three ops in one bundle, closed by a header word
    send(1, 0, 0, 57'h1_0000_0000_00AA);
    send(0, 3, 5, 57'h0_0000_0000_0333);
    send(0, 7, 0, 57'h1FF_FFFF_FFFF_FFFF);
    // R5: pause of 2 on this bundle; the ignored pause on a joining op
    send(1, 2, 2, 57'h0222);
    send(0, 5, 7, 57'h0555);
    send(1, 1, 0, 57'h0111);
    // R6: back-to-back during pause stalls
    send(1, 4, 3, 57'h0444);
    send(1, 6, 0, 57'h0666);
    // R7: duplicate slot dropped, error sticky
    send(0, 6, 0, 57'h0DEAD);
    send(0, 0, 0, 57'h0100);
    idle(2);
    // R8: flush closes the open bundle; second flush has nothing to close
    flush();
    flush();
    idle(2);
    // R9: first op without header opens a bundle
    send(0, 2, 7, 57'h0929);
    send(0, 2, 0, 57'h0BAD);
    send(1, 3, 1, 57'h0303);
    // R8: flush held across pending empties is ignored there
    in_flush = 1;
    idle(12);
    in_flush = 0;
    flush();
    idle(4);
    // R10: idle cycles emit nothing
    for (int k = 0; k < 8; k++) send(1, k, k % 3, 57'(k * 17 + 1));
    flush();
    idle(12);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule